// File: doc/BRIEF.md
# Dual-Port Out-of-Order Read Return Merger

This block merges read data coming back from two independent downstream ports onto a single 64-bit CPU return channel. Up to two reads can be outstanding at once, one per port. The issue side carries a port select, a burst length and a transaction tag. Each port returns its beats on a plain valid/data channel.

The port that returns its first beat earlier owns the CPU channel. Its beats are registered once and sent straight out. Beats from the other port that arrive in the meantime go into a small local buffer. That buffer is replayed immediately after the owning burst ends. Neither port is ever stalled. Every beat on the CPU side carries the tag of its request and a last-beat flag, so the CPU can match returns arriving in either order.

Top module: `rd_return_merger`

## Requirements
- R1: After reset `cpuValid` is low and `issueReady` is high for either port.
- R2: A request is accepted when `issueValid` and `issueReady` are both high at a rising edge. `issuePort` selects port 0 or 1, and `issueLen` holds the beat count minus one. `issueReady` is low while the selected port still has a read that has not been fully delivered to the CPU. It is also low while buffered data is being replayed. This allows at most two outstanding reads, one per port.
- R3: With no burst in progress, a port beat sampled at a rising edge appears on `cpuValid`/`cpuData` from that same edge, one clock after it was presented.
- R4: If both ports present their first beat in the same cycle, port 0's burst goes out first and port 1's is buffered.
- R5: Beats from the non-owning port are stored, four 64-bit entries deep. They are sent only after the owning burst's last beat. Bursts never interleave, and they leave in the order their first beats arrived.
- R6: Back-to-back port beats leave at one beat per clock with no wait state. A buffered burst starts in the clock right after the previous burst's last beat.
- R7: Each CPU beat carries the `issueTag` of its request on `cpuTag`. `cpuLast` is high exactly on the final beat of the request's length.
- R8: Bursts of one to four beats are supported on both ports.
- R9: A valid beat on a port with no outstanding read is ignored and produces no CPU beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Read request present |
| issuePort | input | 1 | Target port of the request |
| issueLen | input | 2 | Beats in the burst minus one |
| issueTag | input | 4 | Tag returned with every beat of this read |
| issueReady | output | 1 | Request can be accepted this cycle |
| p0Valid | input | 1 | Port 0 return beat valid |
| p0Data | input | 64 | Port 0 return data |
| p1Valid | input | 1 | Port 1 return beat valid |
| p1Data | input | 64 | Port 1 return data |
| cpuValid | output | 1 | CPU return beat valid |
| cpuData | output | 64 | CPU return data |
| cpuTag | output | 4 | Tag of the request the beat belongs to |
| cpuLast | output | 1 | Final beat of the request |

## Verification
`issueReady` is combinational and is sampled 1 ns after a falling edge, once the new `issuePort` has settled. A directly forwarded beat is sampled by the block at rising edge N and is visible on the CPU side from edge N. It is therefore checked at the falling edge of that same cycle count. A buffered burst is due in the cycle after the owning burst's last beat; with two back-to-back four-beat bursts tied at cycle N, that is cycle N+4. The bench stamps every port beat and every CPU beat with a shared cycle counter. It compares those stamps, and it checks data, tag and last flag against a scoreboard ordered by first-beat arrival.

// File: rtl/rrm_pkg.sv
`timescale 1ns/1ps
package rrm_pkg;

  typedef enum logic [1:0] {
    SRC_P0  = 2'd0,
    SRC_P1  = 2'd1,
    SRC_BUF = 2'd2
  } srcSel_t;

  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_DIRECT = 2'd1,
    M_REPLAY = 2'd2
  } mode_t;

  typedef struct packed {
    logic    outEn;
    srcSel_t outSrc;
    logic    pushEn;
    logic    pushPort;
  } dpCtrl_t;

endpackage

// File: rtl/rrm_datapath.sv
`timescale 1ns/1ps
module rrm_datapath
  import rrm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [DATA_W-1:0] p0Data,
  input  logic [DATA_W-1:0] p1Data,
  output logic [CNT_W-1:0]  bufCount,
  output logic [DATA_W-1:0] cpuData
);

  logic [DATA_W-1:0] portData [2];
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrNext, rdNext;
  logic [CNT_W-1:0]  count;
  logic              popEn;

  assign portData[0] = p0Data;
  assign portData[1] = p1Data;
  assign popEn       = strobes.outEn && (strobes.outSrc == SRC_BUF);
  assign bufCount    = count;

  // Pointer wrap: natural rollover for power-of-two depth, compare otherwise.
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_wrapPow2
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrapCmp
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.pushEn) mem[wrPtr] <= portData[strobes.pushPort];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.pushEn) wrPtr <= wrNext;
      if (popEn)          rdPtr <= rdNext;
      unique case ({strobes.pushEn, popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuData <= '0;
    end else if (strobes.outEn) begin
      unique case (strobes.outSrc)
        SRC_P0:  cpuData <= p0Data;
        SRC_P1:  cpuData <= p1Data;
        default: cpuData <= mem[rdPtr];
      endcase
    end
  end

endmodule

// File: rtl/rrm_ctrl.sv
`timescale 1ns/1ps
module rrm_ctrl
  import rrm_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int LEN_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             issuePort,
  input  logic [LEN_W-1:0] issueLen,
  input  logic [TAG_W-1:0] issueTag,
  output logic             issueReady,
  input  logic [1:0]       portValid,
  input  logic [CNT_W-1:0] bufCount,
  output dpCtrl_t          strobes,
  output mode_t            mode,
  output logic [1:0]       busyVec,
  output logic             cpuValid,
  output logic [TAG_W-1:0] cpuTag,
  output logic             cpuLast
);

  mode_t            modeQ, modeD;
  logic             curQ, curD;
  logic             busyQ [2];
  logic [TAG_W-1:0] tagQ  [2];
  logic [LEN_W-1:0] lenQ  [2];
  logic [LEN_W-1:0] doneQ [2];
  logic [1:0]       portLive;
  logic             outPort, outLast, accept;

  assign busyVec    = {busyQ[1], busyQ[0]};
  assign mode       = modeQ;
  assign portLive   = portValid & busyVec;
  assign issueReady = !busyVec[issuePort] && (modeQ != M_REPLAY);
  assign accept     = issueValid && issueReady;

  always_comb begin
    strobes = '0;
    outPort = 1'b0;
    modeD   = modeQ;
    curD    = curQ;
    unique case (modeQ)
      M_IDLE: begin
        if (portLive[0]) begin
          strobes.outEn  = 1'b1;
          strobes.outSrc = SRC_P0;
          outPort        = 1'b0;
          if (portLive[1]) begin
            strobes.pushEn   = 1'b1;
            strobes.pushPort = 1'b1;
          end
        end else if (portLive[1]) begin
          strobes.outEn  = 1'b1;
          strobes.outSrc = SRC_P1;
          outPort        = 1'b1;
        end
      end
      M_DIRECT: begin
        outPort = curQ;
        if (portLive[curQ]) begin
          strobes.outEn  = 1'b1;
          strobes.outSrc = curQ ? SRC_P1 : SRC_P0;
        end
        if (portLive[!curQ]) begin
          strobes.pushEn   = 1'b1;
          strobes.pushPort = !curQ;
        end
      end
      default: begin
        outPort = curQ;
        if (bufCount != '0) begin
          strobes.outEn  = 1'b1;
          strobes.outSrc = SRC_BUF;
        end
        if (portLive[curQ]) begin
          strobes.pushEn   = 1'b1;
          strobes.pushPort = curQ;
        end
      end
    endcase

    outLast = strobes.outEn && (doneQ[outPort] == lenQ[outPort]);

    if (strobes.outEn) begin
      if (outLast) begin
        if (modeQ == M_REPLAY) begin
          modeD = M_IDLE;
        end else if ((bufCount != '0) || strobes.pushEn) begin
          modeD = M_REPLAY;
          curD  = !outPort;
        end else begin
          modeD = M_IDLE;
        end
      end else if (modeQ == M_IDLE) begin
        modeD = M_DIRECT;
        curD  = outPort;
      end
    end
  end

  generate
    for (genvar p = 0; p < 2; p++) begin : g_slot
      logic hitIssue, hitOut;
      assign hitIssue = accept && (issuePort == 1'(p));
      assign hitOut   = strobes.outEn && (outPort == 1'(p));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          busyQ[p] <= 1'b0;
          tagQ[p]  <= '0;
          lenQ[p]  <= '0;
          doneQ[p] <= '0;
        end else if (hitIssue) begin
          busyQ[p] <= 1'b1;
          tagQ[p]  <= issueTag;
          lenQ[p]  <= issueLen;
          doneQ[p] <= '0;
        end else if (hitOut) begin
          if (outLast) busyQ[p] <= 1'b0;
          else         doneQ[p] <= doneQ[p] + 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= M_IDLE;
      curQ     <= 1'b0;
      cpuValid <= 1'b0;
      cpuTag   <= '0;
      cpuLast  <= 1'b0;
    end else begin
      modeQ    <= modeD;
      curQ     <= curD;
      cpuValid <= strobes.outEn;
      cpuLast  <= outLast;
      if (strobes.outEn) cpuTag <= tagQ[outPort];
    end
  end

endmodule

// File: rtl/rd_return_merger.sv
`timescale 1ns/1ps
module rd_return_merger
  import rrm_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 4,
  parameter int MAX_BEATS = 4,
  localparam int LEN_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
  localparam int CNT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issuePort,
  input  logic [LEN_W-1:0]  issueLen,
  input  logic [TAG_W-1:0]  issueTag,
  output logic              issueReady,
  input  logic              p0Valid,
  input  logic [DATA_W-1:0] p0Data,
  input  logic              p1Valid,
  input  logic [DATA_W-1:0] p1Data,
  output logic              cpuValid,
  output logic [DATA_W-1:0] cpuData,
  output logic [TAG_W-1:0]  cpuTag,
  output logic              cpuLast
);

  dpCtrl_t          strobes;
  mode_t            mode;
  logic [1:0]       busyVec;
  logic [CNT_W-1:0] bufCount;

  rrm_ctrl #(
    .TAG_W (TAG_W),
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issuePort  (issuePort),
    .issueLen   (issueLen),
    .issueTag   (issueTag),
    .issueReady (issueReady),
    .portValid  ({p1Valid, p0Valid}),
    .bufCount   (bufCount),
    .strobes    (strobes),
    .mode       (mode),
    .busyVec    (busyVec),
    .cpuValid   (cpuValid),
    .cpuTag     (cpuTag),
    .cpuLast    (cpuLast)
  );

  rrm_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (MAX_BEATS),
    .PTR_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .p0Data   (p0Data),
    .p1Data   (p1Data),
    .bufCount (bufCount),
    .cpuData  (cpuData)
  );

endmodule

// File: rtl/rrm_checker.sv
`timescale 1ns/1ps
module rrm_checker
  import rrm_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int CNT_W     = 3,
  parameter int MAX_BEATS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             p0Valid,
  input logic [1:0]       busyVec,
  input mode_t            mode,
  input dpCtrl_t          strobes,
  input logic [CNT_W-1:0] bufCount,
  input logic             cpuValid,
  input logic             cpuLast,
  input logic [TAG_W-1:0] cpuTag
);

  // R5: the replay buffer never exceeds one maximum burst
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    bufCount <= CNT_W'(MAX_BEATS));

  // R5: the control never pops an empty buffer
  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.outEn && strobes.outSrc == SRC_BUF) |-> (bufCount != '0));

  // R3: an idle merger forwards a live port 0 beat on the next edge
  a_r3_direct_latency: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_IDLE && p0Valid && busyVec[0]) |=> cpuValid);

  // R7: the tag holds across the beats of one burst
  a_r7_tag_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !cpuLast) |=> (!cpuValid || $stable(cpuTag)));

  // R9: with nothing outstanding, no beat is produced
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (busyVec == 2'b00) |=> !cpuValid);

endmodule

bind rd_return_merger rrm_checker #(
  .TAG_W     (TAG_W),
  .CNT_W     (CNT_W),
  .MAX_BEATS (MAX_BEATS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .p0Valid  (p0Valid),
  .busyVec  (busyVec),
  .mode     (mode),
  .strobes  (strobes),
  .bufCount (bufCount),
  .cpuValid (cpuValid),
  .cpuLast  (cpuLast),
  .cpuTag   (cpuTag)
);

// File: tb/rd_return_merger_bench.sv
`timescale 1ns/1ps
module rd_return_merger_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic        issuePort = 1'b0;
  logic [1:0]  issueLen = '0;
  logic [3:0]  issueTag = '0;
  logic        issueReady;
  logic        p0Valid, p1Valid;
  logic [63:0] p0Data, p1Data;
  logic        cpuValid;
  logic [63:0] cpuData;
  logic [3:0]  cpuTag;
  logic        cpuLast;

  logic        pValid [2];
  logic [63:0] pData  [2];

  assign p0Valid = pValid[0];
  assign p1Valid = pValid[1];
  assign p0Data  = pData[0];
  assign p1Data  = pData[1];

  always #2 clk = ~clk;

  rd_return_merger u_rd_return_merger (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issuePort  (issuePort),
    .issueLen   (issueLen),
    .issueTag   (issueTag),
    .issueReady (issueReady),
    .p0Valid    (p0Valid),
    .p0Data     (p0Data),
    .p1Valid    (p1Valid),
    .p1Data     (p1Data),
    .cpuValid   (cpuValid),
    .cpuData    (cpuData),
    .cpuTag     (cpuTag),
    .cpuLast    (cpuLast)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int nextId  = 0;
  int doneCount = 0;

  logic [63:0] bData [512][4];
  int  bTag [512];
  int  bLen [512];
  int  bFirstIn [512];
  int  bFirstOut [512];
  int  bGaps [512];
  bit  bDone [512];
  int  portId [2];
  bit  armed [2];
  bit  portPend [2];
  int  inCnt [2];
  int  orderQ [$];
  int  outCnt = 0;
  int  prevOut = 0;
  bit  holdStart = 1'b0;
  bit  randDelay = 1'b0;
  bit  randGaps  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] beatValue(input int id, input int p, input int b);
    return {16'(id), 8'(p), 8'(b), 32'($urandom())};
  endfunction

  // Port-side monitor: stamps arrivals and builds the expected order (port 0 first on a tie)
  always @(posedge clk) begin
    cyc++;
    if (rstN) begin
      for (int p = 0; p < 2; p++) begin
        if (pValid[p] && armed[p]) begin
          int id;
          id = portId[p];
          if (inCnt[p] == 0) begin
            orderQ.push_back(id);
            bFirstIn[id] = cyc;
          end
          bData[id][inCnt[p]] = pData[p];
          if (inCnt[p] == bLen[id] - 1) begin
            inCnt[p] = 0;
            armed[p] = 1'b0;
          end else begin
            inCnt[p]++;
          end
        end
      end
    end
  end

  // CPU-side scoreboard, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN && cpuValid) begin
      if (orderQ.size() == 0) begin
        chk(1'b0, "R9 beat with nothing expected", cpuData, 64'd0);
      end else begin
        int  id;
        bit  expLast;
        id = orderQ[0];
        expLast = (outCnt == bLen[id] - 1);
        chk(cpuData == bData[id][outCnt], "R5 data order", cpuData, bData[id][outCnt]);
        chk(cpuTag == 4'(bTag[id]), "R7 tag", 64'(cpuTag), 64'(bTag[id]));
        chk(cpuLast == expLast, "R7 last flag", 64'(cpuLast), 64'(expLast));
        if (outCnt == 0) bFirstOut[id] = cyc;
        else if (cyc != prevOut + 1) bGaps[id]++;
        prevOut = cyc;
        if (expLast) begin
          void'(orderQ.pop_front());
          outCnt = 0;
          bDone[id] = 1'b1;
          doneCount++;
        end else begin
          outCnt++;
        end
      end
    end
  end

  task automatic portDrive(input int p);
    forever begin
      int id;
      wait (portPend[p]);
      wait (!holdStart);
      id = portId[p];
      if (randDelay) repeat ($urandom_range(0, 4)) @(negedge clk);
      @(negedge clk);
      for (int b = 0; b < bLen[id]; b++) begin
        if (b > 0 && randGaps) begin
          while ($urandom_range(0, 3) == 0) begin
            pValid[p] = 1'b0;
            @(negedge clk);
          end
        end
        pValid[p] = 1'b1;
        pData[p]  = beatValue(id, p, b);
        @(negedge clk);
      end
      pValid[p]   = 1'b0;
      portPend[p] = 1'b0;
    end
  endtask

  task automatic doIssue(input int p, input int nb, input int tg, output int id);
    @(negedge clk);
    issueValid = 1'b1;
    issuePort  = p[0];
    issueLen   = 2'(nb - 1);
    issueTag   = 4'(tg);
    #1;
    while (!issueReady) begin
      @(negedge clk);
      #1;
    end
    id = nextId;
    nextId++;
    bTag[id]    = tg;
    bLen[id]    = nb;
    bGaps[id]   = 0;
    portId[p]   = id;
    armed[p]    = 1'b1;
    portPend[p] = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic readyFor(input int p, output bit r);
    issuePort = p[0];
    #1;
    r = issueReady;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d completed reads", doneCount, nextId);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      pValid[p] = 1'b0;
      pData[p]  = '0;
      armed[p]  = 1'b0;
      portPend[p] = 1'b0;
      inCnt[p]  = 0;
    end
  end

  initial begin
    fork
      portDrive(0);
      portDrive(1);
    join_none
  end

  initial begin
    int idA, idB;
    bit r;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(cpuValid == 1'b0, "R1 cpuValid after reset", 64'(cpuValid), 64'd0);
    readyFor(0, r);
    chk(r == 1'b1, "R1 ready port 0", 64'(r), 64'd1);
    readyFor(1, r);
    chk(r == 1'b1, "R1 ready port 1", 64'(r), 64'd1);

    // R3 R8: single beat on port 1 from idle
    doIssue(1, 1, 5, idA);
    wait (bDone[idA]);
    chk(bFirstOut[idA] == bFirstIn[idA], "R3 single-beat latency", 64'(bFirstOut[idA]), 64'(bFirstIn[idA]));

    // R3 R6 R8: four back-to-back beats on port 0
    doIssue(0, 4, 9, idA);
    wait (bDone[idA]);
    chk(bFirstOut[idA] == bFirstIn[idA], "R3 burst latency", 64'(bFirstOut[idA]), 64'(bFirstIn[idA]));
    chk(bGaps[idA] == 0, "R6 no wait states", 64'(bGaps[idA]), 64'd0);

    // R4 R5 R6 R2: both ports start in the same cycle
    holdStart = 1'b1;
    doIssue(0, 4, 3, idA);
    doIssue(1, 4, 12, idB);
    readyFor(0, r);
    chk(r == 1'b0, "R2 port 0 busy blocks issue", 64'(r), 64'd0);
    readyFor(1, r);
    chk(r == 1'b0, "R2 port 1 busy blocks issue", 64'(r), 64'd0);
    @(negedge clk);
    holdStart = 1'b0;
    wait (bDone[idA]);
    readyFor(0, r);
    chk(r == 1'b0, "R2 replay blocks issue", 64'(r), 64'd0);
    wait (bDone[idB]);
    chk(bFirstIn[idA] == bFirstIn[idB], "R4 tie arranged", 64'(bFirstIn[idB]), 64'(bFirstIn[idA]));
    chk(bFirstOut[idA] == bFirstIn[idA], "R4 port 0 wins tie", 64'(bFirstOut[idA]), 64'(bFirstIn[idA]));
    chk(bFirstOut[idB] == bFirstIn[idA] + 4, "R5 replay follows first burst", 64'(bFirstOut[idB]), 64'(bFirstIn[idA] + 4));
    chk(bGaps[idA] + bGaps[idB] == 0, "R6 gapless merge", 64'(bGaps[idA] + bGaps[idB]), 64'd0);
    @(negedge clk);
    readyFor(1, r);
    chk(r == 1'b1, "R2 ready after drain", 64'(r), 64'd1);

    // R9: unrequested beats on both ports
    @(negedge clk);
    pValid[1] = 1'b1;
    pData[1]  = 64'hDEAD_BEEF_0000_0001;
    pValid[0] = 1'b1;
    pData[0]  = 64'hDEAD_BEEF_0000_0002;
    @(negedge clk);
    pValid[0] = 1'b0;
    pValid[1] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(cpuValid == 1'b0, "R9 stray beat ignored", 64'(cpuValid), 64'd0);
      @(negedge clk);
    end

    // R5 R7 R8: constrained random traffic against the scoreboard
    randDelay = 1'b1;
    randGaps  = 1'b1;
    for (int n = 0; n < 250; n++) begin
      int dummy;
      repeat ($urandom_range(0, 3)) @(negedge clk);
      doIssue(int'($urandom_range(0, 1)), int'($urandom_range(1, 4)), int'($urandom_range(0, 15)), dummy);
    end
    wait (doneCount == nextId);
    repeat (4) @(negedge clk);
    chk(orderQ.size() == 0, "R5 all bursts delivered", 64'(orderQ.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule